// File: doc/BRIEF.md
# Stepped LED Brightness Fade Controller

This block holds the brightness code for one LED bank and moves it toward a target code that a host writes. The host writes a 5-bit target with a strobe and a 2-bit fade rate with a second strobe. When fading is enabled and at least one LED of the bank is switched on, the code walks toward the target one binary count at a time. Each count waits a fixed number of 1 ms timebase ticks, and the rate field sets that number. When fading is off, or no LED is enabled, the code takes the target value at once.

A fade that is running can be redirected to a new target from the point it has reached. Its rate can be changed for the remaining steps. It can be aborted by writing rate 00, which makes the code land on the final target at once. A busy flag shows when a fade still has steps to go. Turning the code into an analog current and driving the sinks are left to other blocks.

Top module: `led_fade_ctrl`

## Requirements
- R1: A synchronous reset drives the level output to 00h and the busy flag low. It also clears the stored target to 00h and sets the stored rate to 00 (fading off).
- R2: The rate field is decoded as follows: 00 = no fading, 01 = one step per 8 ticks, 10 = one step per 16 ticks, 11 = one step per 32 ticks. The level changes on the clock edge that samples the Nth tick counted since the last write, or since the last step.
- R3: Each step changes the level by exactly one count in the direction of the target. The level never passes the target, and stepping stops once it equals the target.
- R4: With the stored rate at 00, a target write appears on the level output on the next clock edge.
- R5: A target write during a fade redirects the fade from the present level toward the new target and restarts the tick count.
- R6: A nonzero rate write during a fade leaves the level where it is, restarts the tick count, and makes the following steps use the new interval.
- R7: A rate write of 00 during a fade cancels it: on the next clock edge the level equals the stored target.
- R8: While the any-LED-enabled input is low, the level follows the stored target on the next edge and no stepping takes place.
- R9: Busy is high exactly when the level differs from the stored target, the stored rate is nonzero and the any-LED-enabled input is high.
- R10: A target write and a rate write in the same cycle both take effect. If the new rate is 00 the level jumps to the new target; otherwise a fade toward the new target starts with the new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_wr | input | 1 | Strobe: load a new target code |
| tgt_val | input | 5 | Target code |
| rate_wr | input | 1 | Strobe: load a new fade rate |
| rate_val | input | 2 | Fade rate (00 off, 01/10/11 = 8/16/32 ticks per step) |
| any_led_on | input | 1 | High when any LED of the bank is enabled |
| tick_1ms | input | 1 | One-cycle timebase pulse |
| level | output | 5 | Present brightness code |
| busy | output | 1 | Fade in progress |

## Verification
Two things can happen in the same cycle: a step can fall due while a target or rate write arrives, and a target write can coincide with a rate write. The bench drives a tick on every second cycle and places strobes on both tick and non-tick cycles during running fades, so some writes fall on the very edge where a step was due. It also issues paired target and rate strobes, with both a zero and a nonzero new rate. A behavioural reference model is compared on every clock. It judges that the write wins: no step is taken, the count restarts, and the level either holds, jumps or starts a new fade, as each requirement states.

// File: rtl/fade_pkg.sv
package fade_pkg;

    localparam int LVL_W_DEF      = 5;
    localparam int BASE_TICKS_DEF = 8;

    typedef enum logic [1:0] {
        FADE_OFF  = 2'b00,
        FADE_FAST = 2'b01,
        FADE_MID  = 2'b10,
        FADE_SLOW = 2'b11
    } fade_rate_e;

    // Number of timebase ticks between two level steps for a rate.
    function automatic int unsigned step_interval(input fade_rate_e r,
                                                  input int unsigned base);
        case (r)
            FADE_FAST: return base;
            FADE_MID:  return base * 2;
            FADE_SLOW: return base * 4;
            default:   return base;
        endcase
    endfunction

endpackage

// File: rtl/fade_cfg_regs.sv
module fade_cfg_regs
    import fade_pkg::*;
#(
    parameter int LVL_W = LVL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tgt_wr,
    input  logic [LVL_W-1:0] tgt_val,
    input  logic             rate_wr,
    input  fade_rate_e       rate_val,
    output logic [LVL_W-1:0] tgt_q,
    output fade_rate_e       rate_q,
    output logic [LVL_W-1:0] tgt_nxt,
    output fade_rate_e       rate_nxt,
    output logic             any_wr
);

    always_comb begin
        tgt_nxt  = tgt_wr  ? tgt_val  : tgt_q;
        rate_nxt = rate_wr ? rate_val : rate_q;
        any_wr   = tgt_wr | rate_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            rate_q <= FADE_OFF;
        end else begin
            tgt_q  <= tgt_nxt;
            rate_q <= rate_nxt;
        end
    end

endmodule

// File: rtl/fade_step_timer.sv
module fade_step_timer
    import fade_pkg::*;
#(
    parameter int BASE_TICKS = BASE_TICKS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       tick,
    input  fade_rate_e rate,
    output logic       step_due
);

    localparam int CNT_W = $clog2(BASE_TICKS * 4);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        limit_m1 = CNT_W'(step_interval(rate, BASE_TICKS) - 1);
        step_due = !clear && tick && (cnt == limit_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= step_due ? '0 : cnt + 1'b1;
        end
    end

    AST_STEP_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (rst)
        step_due |=> (cnt == '0)); // R2

    AST_COUNT_WITHIN_INTERVAL: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (cnt <= limit_m1)); // R6

endmodule

// File: rtl/fade_level_track.sv
module fade_level_track
    import fade_pkg::*;
#(
    parameter int LVL_W = LVL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fade_on,
    input  logic             step_due,
    input  logic [LVL_W-1:0] tgt_q,
    input  logic [LVL_W-1:0] tgt_nxt,
    output logic [LVL_W-1:0] level_q
);

    logic             go_up;
    logic [LVL_W-1:0] stepped;

    always_comb begin
        go_up   = level_q < tgt_q;
        stepped = go_up ? level_q + 1'b1 : level_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (!fade_on) begin
            level_q <= tgt_nxt;
        end else if (step_due && (level_q != tgt_q)) begin
            level_q <= stepped;
        end
    end

    AST_SINGLE_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fade_on && step_due && (level_q != tgt_q)) |=>
            ((level_q == LVL_W'($past(level_q) + 1'b1)) ||
             (level_q == LVL_W'($past(level_q) - 1'b1)))); // R3

endmodule

// File: rtl/led_fade_ctrl.sv
module led_fade_ctrl
    import fade_pkg::*;
#(
    parameter int LVL_W      = LVL_W_DEF,
    parameter int BASE_TICKS = BASE_TICKS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tgt_wr,
    input  logic [LVL_W-1:0] tgt_val,
    input  logic             rate_wr,
    input  logic [1:0]       rate_val,
    input  logic             any_led_on,
    input  logic             tick_1ms,
    output logic [LVL_W-1:0] level,
    output logic             busy
);

    logic [LVL_W-1:0] tgt_q;
    logic [LVL_W-1:0] tgt_nxt;
    fade_rate_e       rate_q;
    fade_rate_e       rate_nxt;
    logic             any_wr;
    logic             fade_on;
    logic             tmr_clear;
    logic             step_due;

    fade_cfg_regs #(.LVL_W(LVL_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .tgt_wr   (tgt_wr),
        .tgt_val  (tgt_val),
        .rate_wr  (rate_wr),
        .rate_val (fade_rate_e'(rate_val)),
        .tgt_q    (tgt_q),
        .rate_q   (rate_q),
        .tgt_nxt  (tgt_nxt),
        .rate_nxt (rate_nxt),
        .any_wr   (any_wr)
    );

    always_comb begin
        fade_on   = (rate_nxt != FADE_OFF) && any_led_on;
        tmr_clear = !fade_on || any_wr || (level == tgt_q);
        busy      = (rate_q != FADE_OFF) && any_led_on && (level != tgt_q);
    end

    fade_step_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear    (tmr_clear),
        .tick     (tick_1ms),
        .rate     (rate_q),
        .step_due (step_due)
    );

    fade_level_track #(.LVL_W(LVL_W)) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .fade_on  (fade_on),
        .step_due (step_due),
        .tgt_q    (tgt_q),
        .tgt_nxt  (tgt_nxt),
        .level_q  (level)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ((level == '0) && !busy)); // R1

    AST_OFF_APPLIES_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (tgt_wr && !rate_wr && (rate_q == FADE_OFF)) |=> (level == $past(tgt_val))); // R4

    AST_CANCEL_LANDS_ON_TARGET: assert property (@(posedge clk) disable iff (rst)
        (rate_wr && (rate_val == 2'b00) && !tgt_wr) |=> (level == $past(tgt_q))); // R7

    AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!any_led_on && !tgt_wr) |=> (level == $past(tgt_q))); // R8

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && (level < tgt_q)) |=> (level <= $past(tgt_q))); // R3

    AST_PAIR_OFF_JUMPS: assert property (@(posedge clk) disable iff (rst)
        (tgt_wr && rate_wr && (rate_val == 2'b00)) |=> (level == $past(tgt_val))); // R10

endmodule

// File: tb/test_led_fade_ctrl.sv
module test_led_fade_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tgt_wr = 1'b0;
    logic [4:0] tgt_val = '0;
    logic       rate_wr = 1'b0;
    logic [1:0] rate_val = '0;
    logic       any_led_on = 1'b0;
    logic       tick_1ms = 1'b0;
    logic [4:0] level;
    logic       busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string req_tag = "R1";

    // reference model state
    int m_level = 0, m_tgt = 0, m_rate = 0, m_cnt = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    led_fade_ctrl i_led_fade_ctrl (
        .clk(clk), .rst(rst), .tgt_wr(tgt_wr), .tgt_val(tgt_val),
        .rate_wr(rate_wr), .rate_val(rate_val), .any_led_on(any_led_on),
        .tick_1ms(tick_1ms), .level(level), .busy(busy)
    );

    // timebase: a tick on every second cycle
    always @(negedge clk) tick_1ms <= ~tick_1ms;

    // behavioural reference model
    always @(posedge clk) begin
        int nt, nr, ticks_needed;
        if (rst) begin
            m_level = 0; m_tgt = 0; m_rate = 0; m_cnt = 0;
        end else begin
            nt = tgt_wr  ? int'(tgt_val)  : m_tgt;
            nr = rate_wr ? int'(rate_val) : m_rate;
            if (nr == 0 || !any_led_on) begin
                m_level = nt; m_cnt = 0;
            end else if (tgt_wr || rate_wr || m_level == m_tgt) begin
                m_cnt = 0;
            end else if (tick_1ms) begin
                ticks_needed = 8 << (m_rate - 1);
                m_cnt++;
                if (m_cnt == ticks_needed) begin
                    m_cnt = 0;
                    m_level = (m_level < m_tgt) ? m_level + 1 : m_level - 1;
                end
            end
            m_tgt = nt; m_rate = nr;
        end
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // compare away from the edge, every clock
    always @(posedge clk) begin
        bit m_busy;
        #1;
        m_busy = (m_level != m_tgt) && (m_rate != 0) && any_led_on;
        n_cmp++;
        if (int'(level) != m_level) begin
            n_bad++;
            $display("FAIL %s level: actual %0d expected %0d (cycle %0d)", req_tag, level, m_level, cyc);
        end
        n_cmp++;
        if (busy !== m_busy) begin
            n_bad++;
            $display("FAIL R9 busy (phase %s): actual %0b expected %0b (cycle %0d)", req_tag, busy, m_busy, cyc);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            report();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_tgt(input int v);
        @(negedge clk); tgt_wr = 1'b1; tgt_val = 5'(v);
        @(negedge clk); tgt_wr = 1'b0;
    endtask

    task automatic put_rate(input int r);
        @(negedge clk); rate_wr = 1'b1; rate_val = 2'(r);
        @(negedge clk); rate_wr = 1'b0;
    endtask

    task automatic put_both(input int v, input int r);
        @(negedge clk); tgt_wr = 1'b1; tgt_val = 5'(v); rate_wr = 1'b1; rate_val = 2'(r);
        @(negedge clk); tgt_wr = 1'b0; rate_wr = 1'b0;
    endtask

    // explicit check: cycles from the write edge until the first step
    task automatic time_first_step(input int rate, input int from, input int to);
        int start_cyc, waited;
        put_rate(0); put_tgt(from); put_rate(rate);
        start_cyc = cyc;
        @(negedge clk); tgt_wr = 1'b1; tgt_val = 5'(to);
        @(negedge clk); tgt_wr = 1'b0;
        waited = 0;
        while (int'(level) == from && waited < 200) begin
            @(negedge clk); waited++;
        end
        n_cmp++;
        if (int'(level) != from + 1 || waited < (8 << (rate - 1)) * 2 - 3 ||
            waited > (8 << (rate - 1)) * 2 + 1) begin
            n_bad++;
            $display("FAIL R2 rate %0d first step: actual level %0d after %0d cycles expected level %0d after about %0d",
                     rate, level, waited, from + 1, (8 << (rate - 1)) * 2);
        end
        if (start_cyc < 0) $display("unreachable");
    endtask

    initial begin
        req_tag = "R1";
        idle(3);
        @(negedge clk); rst = 1'b0;
        n_cmp++;
        if (level !== 5'd0 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual level %0d busy %0b expected 0 0", level, busy);
        end
        any_led_on = 1'b1;

        req_tag = "R4";
        put_tgt(20); idle(3); put_tgt(4); idle(2);

        req_tag = "R2";
        time_first_step(1, 10, 14); idle(40);
        time_first_step(2, 6, 8);  idle(80);
        time_first_step(3, 6, 7);  idle(80);

        req_tag = "R3";
        put_rate(1); put_tgt(16); idle(150);
        put_tgt(12); idle(150);

        req_tag = "R5";
        put_tgt(31); idle(70); put_tgt(10); idle(7); put_tgt(22); idle(200);

        req_tag = "R6";
        put_tgt(4); idle(37); put_rate(3); idle(90); put_rate(2); idle(41);
        put_rate(1); idle(200);

        req_tag = "R7";
        put_tgt(28); idle(50); put_rate(0); idle(5);

        req_tag = "R8";
        any_led_on = 1'b0; put_rate(1); put_tgt(5); idle(10); put_tgt(19); idle(10);
        any_led_on = 1'b1; put_tgt(9); idle(40);
        @(negedge clk); any_led_on = 1'b0; idle(5);
        any_led_on = 1'b1;

        req_tag = "R10";
        put_both(25, 0); idle(4);
        put_both(20, 2); idle(60);
        put_both(27, 3); idle(17);
        put_both(5, 0); idle(4);

        req_tag = "R9";
        put_both(8, 1); idle(100);
        idle(5);
        report();
    end

endmodule